// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control registers of a small processor core and serves them through an index-addressed read port and write port. It keeps a status byte, a backup status byte, a second-level backup status byte, a condition flag, two saved program counters and two spare 32-bit words. Several of these partial registers are packed into one 32-bit status word on read and unpacked from one on write.

The core's live stack pointer sits in the general register file, outside this block. The block keeps two shadow copies of it, one for interrupt mode and one for user mode. Bit 7 of the status byte selects the stack mode. When a status write flips that bit, the block saves the live pointer into the shadow of the mode being left and drives the other shadow back into the general register file through a one-cycle update strobe.

Reads are combinational from the current state. Writes take effect at the rising clock edge, so a read of an index in the same cycle as a write to that index returns the old contents.

Top module: `crf_banked_top`

## Requirements
- R1: After reset every register is zero and the stack mode is 0. Index 2 then reads the live stack pointer input `sp_cur`, every other index reads 0, and `sp_upd_en` is low while no write is applied.
- R2: Index 0 reads bits 15:8 = backup status AND 0xC1 and bits 7:0 = (status AND 0xC0) OR the condition flag in bit 0. Bits 31:16 read 0.
- R3: A write to index 0 loads the backup status from data bits 15:8, the status byte from bits 7:0 and the condition flag from bit 0.
- R4: A write to index 0 that changes status bit 7 from 0 to 1 saves `sp_cur` into the interrupt-stack shadow. In the same cycle it drives the user-stack shadow on `sp_upd_data` with `sp_upd_en` high.
- R5: A write to index 0 that changes status bit 7 from 1 to 0 saves `sp_cur` into the user-stack shadow. In the same cycle it drives the interrupt-stack shadow on `sp_upd_data` with `sp_upd_en` high.
- R6: A write to index 0 that leaves status bit 7 unchanged does not raise `sp_upd_en` and leaves both shadows unchanged.
- R7: Index 2 (interrupt stack) reaches the live pointer when the stack mode is 0 and its shadow when the mode is 1. Index 3 (user stack) reaches the live pointer when the mode is 1 and its shadow when the mode is 0. This routing applies to reads (through `sp_cur`) and to writes (through `sp_upd_en`/`sp_upd_data`).
- R8: Index 6 (backup PC) and index 8 (second-level backup PC) store all 32 written bits and read back with bit 0 forced to 0.
- R9: Index 7 (second-level backup status) stores data bits 7:0 and reads back that byte AND 0xC1.
- R10: Index 1 reads the condition flag in bit 0, with all other bits 0. A write to index 1 sets the flag from data bit 0 and changes nothing else.
- R11: Indices 4 and 5 are plain 32-bit registers. Indices 9 to 15 read 0 and ignore writes.
- R12: A read of an index in the same cycle as a write to it returns the old value. The new value is visible from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_idx | input | 4 | Control register index to read |
| rd_data | output | 32 | Read data, combinational |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Control register index to write |
| wr_data | input | 32 | Write data |
| sp_cur | input | 32 | Current live stack pointer from the general register file |
| sp_upd_en | output | 1 | Load strobe for the live stack pointer |
| sp_upd_data | output | 32 | New live stack pointer value |

## Verification
A stack-mode bit that is wrong, or a shadow that was not saved, does not show up when the status write happens. It shows up at the next read of index 2 or 3, which returns the wrong bank, or at the next mode flip, which restores a stale pointer through `sp_upd_data`. The bench therefore models the external stack pointer and reads both stack indices after every mode change. Packing and masking errors show up at once as wrong bits in the next status, backup PC or backup status read. The checker compares the shadows one cycle after each flip with the pointer value sampled at the flip.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;
  localparam int BYTE_W = 8;

  localparam int CR_STATUS = 0;
  localparam int CR_COND   = 1;
  localparam int CR_ISTK   = 2;
  localparam int CR_USTK   = 3;
  localparam int CR_SPARE  = 4;
  localparam int N_SPARE   = 2;
  localparam int CR_BPC    = 6;
  localparam int CR_BBSTAT = 7;
  localparam int CR_BBPC   = 8;

  localparam logic [BYTE_W-1:0] BSTAT_KEEP = 8'hC1;
  localparam logic [BYTE_W-1:0] STAT_KEEP  = 8'hC0;
  localparam int SM_BIT = 7;

  function automatic logic [DATA_W-1:0] pack_status(input logic [BYTE_W-1:0] bstat,
                                                    input logic [BYTE_W-1:0] stat,
                                                    input logic cond);
    logic [BYTE_W-1:0] lo;
    lo = (stat & STAT_KEEP) | {{(BYTE_W-1){1'b0}}, cond};
    return {{(DATA_W-2*BYTE_W){1'b0}}, bstat & BSTAT_KEEP, lo};
  endfunction

  function automatic logic [DATA_W-1:0] even_pc(input logic [DATA_W-1:0] v);
    return {v[DATA_W-1:1], 1'b0};
  endfunction

  function automatic logic [DATA_W-1:0] view_bbstat(input logic [BYTE_W-1:0] b);
    return {{(DATA_W-BYTE_W){1'b0}}, b & BSTAT_KEEP};
  endfunction

  function automatic logic idx_is(input logic [IDX_W-1:0] idx, input int code);
    return idx == IDX_W'(code);
  endfunction
endpackage

// File: rtl/crf_status_unit.sv
module crf_status_unit
  import crf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [2*BYTE_W-1:0]   wr_lo,
  output logic [BYTE_W-1:0]     stat_q,
  output logic [BYTE_W-1:0]     bstat_q,
  output logic                  cond_q,
  output logic                  sm_now,
  output logic                  flip_up,
  output logic                  flip_down
);
  logic st_hit, cond_hit, new_sm;

  assign st_hit    = wr_en && idx_is(wr_idx, CR_STATUS);
  assign cond_hit  = wr_en && idx_is(wr_idx, CR_COND);
  assign sm_now    = stat_q[SM_BIT];
  assign new_sm    = wr_lo[SM_BIT];
  assign flip_up   = st_hit && !sm_now && new_sm;
  assign flip_down = st_hit && sm_now && !new_sm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      bstat_q <= '0;
      cond_q  <= 1'b0;
    end else if (st_hit) begin
      bstat_q <= wr_lo[2*BYTE_W-1:BYTE_W];
      stat_q  <= wr_lo[BYTE_W-1:0];
      cond_q  <= wr_lo[0];
    end else if (cond_hit) begin
      cond_q  <= wr_lo[0];
    end
  end
endmodule

// File: rtl/crf_stack_bank.sv
module crf_stack_bank
  import crf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sm_now,
  input  logic              flip_up,
  input  logic              flip_down,
  input  logic [DATA_W-1:0] sp_cur,
  output logic [DATA_W-1:0] spi_q,
  output logic [DATA_W-1:0] spu_q,
  output logic              sp_upd_en,
  output logic [DATA_W-1:0] sp_upd_data
);
  logic istk_hit, ustk_hit;

  assign istk_hit = wr_en && idx_is(wr_idx, CR_ISTK);
  assign ustk_hit = wr_en && idx_is(wr_idx, CR_USTK);

  always_comb begin
    sp_upd_en   = 1'b0;
    sp_upd_data = '0;
    if (flip_up) begin
      sp_upd_en   = 1'b1;
      sp_upd_data = spu_q;
    end else if (flip_down) begin
      sp_upd_en   = 1'b1;
      sp_upd_data = spi_q;
    end else if ((istk_hit && !sm_now) || (ustk_hit && sm_now)) begin
      sp_upd_en   = 1'b1;
      sp_upd_data = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spi_q <= '0;
      spu_q <= '0;
    end else begin
      if (flip_up)                    spi_q <= sp_cur;
      else if (istk_hit && sm_now)    spi_q <= wr_data;
      if (flip_down)                  spu_q <= sp_cur;
      else if (ustk_hit && !sm_now)   spu_q <= wr_data;
    end
  end
endmodule

// File: rtl/crf_aux_regs.sv
module crf_aux_regs
  import crf_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [DATA_W-1:0]              bpc_q,
  output logic [DATA_W-1:0]              bbpc_q,
  output logic [BYTE_W-1:0]              bbstat_q,
  output logic [N_SPARE-1:0][DATA_W-1:0] spare_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bpc_q    <= '0;
      bbpc_q   <= '0;
      bbstat_q <= '0;
    end else if (wr_en) begin
      if (idx_is(wr_idx, CR_BPC))    bpc_q    <= wr_data;
      if (idx_is(wr_idx, CR_BBPC))   bbpc_q   <= wr_data;
      if (idx_is(wr_idx, CR_BBSTAT)) bbstat_q <= wr_data[BYTE_W-1:0];
    end
  end

  for (genvar g = 0; g < N_SPARE; g++) begin : g_spare
    always_ff @(posedge clk) begin
      if (!rst_n)
        spare_q[g] <= '0;
      else if (wr_en && idx_is(wr_idx, CR_SPARE + g))
        spare_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/crf_read_mux.sv
module crf_read_mux
  import crf_pkg::*;
(
  input  logic [IDX_W-1:0]               rd_idx,
  input  logic [BYTE_W-1:0]              stat_q,
  input  logic [BYTE_W-1:0]              bstat_q,
  input  logic                           cond_q,
  input  logic                           sm_now,
  input  logic [DATA_W-1:0]              sp_cur,
  input  logic [DATA_W-1:0]              spi_q,
  input  logic [DATA_W-1:0]              spu_q,
  input  logic [DATA_W-1:0]              bpc_q,
  input  logic [DATA_W-1:0]              bbpc_q,
  input  logic [BYTE_W-1:0]              bbstat_q,
  input  logic [N_SPARE-1:0][DATA_W-1:0] spare_q,
  output logic [DATA_W-1:0]              rd_data
);
  always_comb begin
    rd_data = '0;
    if (idx_is(rd_idx, CR_STATUS)) rd_data = pack_status(bstat_q, stat_q, cond_q);
    if (idx_is(rd_idx, CR_COND))   rd_data = {{(DATA_W-1){1'b0}}, cond_q};
    if (idx_is(rd_idx, CR_ISTK))   rd_data = sm_now ? spi_q : sp_cur;
    if (idx_is(rd_idx, CR_USTK))   rd_data = sm_now ? sp_cur : spu_q;
    if (idx_is(rd_idx, CR_BPC))    rd_data = even_pc(bpc_q);
    if (idx_is(rd_idx, CR_BBPC))   rd_data = even_pc(bbpc_q);
    if (idx_is(rd_idx, CR_BBSTAT)) rd_data = view_bbstat(bbstat_q);
    for (int g = 0; g < N_SPARE; g++)
      if (idx_is(rd_idx, CR_SPARE + g)) rd_data = spare_q[g];
  end
endmodule

// File: rtl/crf_banked_top.sv
module crf_banked_top
  import crf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] sp_cur,
  output logic              sp_upd_en,
  output logic [DATA_W-1:0] sp_upd_data
);
  logic [BYTE_W-1:0]              stat_q, bstat_q, bbstat_q;
  logic                           cond_q, sm_now, flip_up, flip_down;
  logic [DATA_W-1:0]              spi_q, spu_q, bpc_q, bbpc_q;
  logic [N_SPARE-1:0][DATA_W-1:0] spare_q;

  crf_status_unit status_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_lo(wr_data[2*BYTE_W-1:0]), .stat_q(stat_q), .bstat_q(bstat_q),
    .cond_q(cond_q), .sm_now(sm_now), .flip_up(flip_up), .flip_down(flip_down)
  );

  crf_stack_bank stack_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sm_now(sm_now), .flip_up(flip_up), .flip_down(flip_down), .sp_cur(sp_cur),
    .spi_q(spi_q), .spu_q(spu_q), .sp_upd_en(sp_upd_en), .sp_upd_data(sp_upd_data)
  );

  crf_aux_regs aux_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .bpc_q(bpc_q), .bbpc_q(bbpc_q), .bbstat_q(bbstat_q), .spare_q(spare_q)
  );

  crf_read_mux rmux_i (
    .rd_idx(rd_idx), .stat_q(stat_q), .bstat_q(bstat_q), .cond_q(cond_q),
    .sm_now(sm_now), .sp_cur(sp_cur), .spi_q(spi_q), .spu_q(spu_q),
    .bpc_q(bpc_q), .bbpc_q(bbpc_q), .bbstat_q(bbstat_q), .spare_q(spare_q),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/crf_banked_chk.sv
module crf_banked_chk
  import crf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] sp_cur,
  input logic              sp_upd_en,
  input logic [DATA_W-1:0] sp_upd_data,
  input logic              sm_now,
  input logic              flip_up,
  input logic              flip_down,
  input logic [DATA_W-1:0] spi_q,
  input logic [DATA_W-1:0] spu_q
);
  AST_UP_LOADS_USER: assert property (@(posedge clk) disable iff (!rst_n)
    flip_up |-> (sp_upd_en && sp_upd_data == spu_q)); // R4
  AST_UP_SAVES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    flip_up |=> (spi_q == $past(sp_cur) && sm_now)); // R4
  AST_DOWN_LOADS_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    flip_down |-> (sp_upd_en && sp_upd_data == spi_q)); // R5
  AST_DOWN_SAVES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    flip_down |=> (spu_q == $past(sp_cur) && !sm_now)); // R5
  AST_SAME_MODE_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx_is(wr_idx, CR_STATUS) && wr_data[SM_BIT] == sm_now)
      |-> (!sp_upd_en && !flip_up && !flip_down)); // R6
  AST_SP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sp_upd_en |-> wr_en); // R7
  AST_BPC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_is(rd_idx, CR_BPC) || idx_is(rd_idx, CR_BBPC)) |-> !rd_data[0]); // R8
  AST_BBSTAT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    idx_is(rd_idx, CR_BBSTAT) |-> ((rd_data & ~DATA_W'(BSTAT_KEEP)) == '0)); // R9
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx > IDX_W'(CR_BBPC)) |-> (rd_data == '0)); // R11
endmodule

bind crf_banked_top crf_banked_chk chk_i (.*);

// File: tb/crf_banked_top_tb_top.sv
module crf_banked_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] sp_cur;
  logic        sp_upd_en;
  logic [31:0] sp_upd_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam logic [31:0] SP_INIT = 32'h0000_A000;
  logic [31:0] sp_reg;
  assign sp_cur = sp_reg;

  always #4 clk = ~clk;

  // External general-register stack pointer model
  always @(posedge clk) begin
    if (!rst_n) sp_reg <= SP_INIT;
    else if (sp_upd_en) sp_reg <= sp_upd_data;
  end

  crf_banked_top dut_i (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sp_cur(sp_cur),
    .sp_upd_en(sp_upd_en), .sp_upd_data(sp_upd_data)
  );

  // {write enable, write index, write data, read index, expected read}
  localparam int NV = 20;
  localparam logic [72:0] TBL [0:NV-1] = '{
    {1'b1, 4'd4,  32'h1234_5678, 4'd4, 32'h1234_5678}, // R11 spare 0
    {1'b1, 4'd5,  32'hCAFE_F00D, 4'd5, 32'hCAFE_F00D}, // R11 spare 1
    {1'b1, 4'd9,  32'hFFFF_FFFF, 4'd9, 32'h0000_0000}, // R11 unassigned
    {1'b1, 4'd6,  32'h8000_0003, 4'd6, 32'h8000_0002}, // R8 backup PC
    {1'b1, 4'd8,  32'h0000_0101, 4'd8, 32'h0000_0100}, // R8 second PC
    {1'b1, 4'd7,  32'h0000_01FF, 4'd7, 32'h0000_00C1}, // R9
    {1'b1, 4'd1,  32'h0000_0003, 4'd1, 32'h0000_0001}, // R10 set
    {1'b1, 4'd1,  32'hFFFF_FFFE, 4'd0, 32'h0000_0000}, // R10 clear
    {1'b1, 4'd3,  32'h0000_B000, 4'd3, 32'h0000_B000}, // R7 user shadow
    {1'b1, 4'd2,  32'h0000_A100, 4'd2, 32'h0000_A100}, // R7 live via intr
    {1'b1, 4'd0,  32'h0000_FF81, 4'd0, 32'h0000_C181}, // R2 R3 R4 flip up
    {1'b1, 4'd10, 32'h0000_0055, 4'd2, 32'h0000_A100}, // R4 intr shadow
    {1'b0, 4'd0,  32'h0000_0000, 4'd3, 32'h0000_B000}, // R4 live restored
    {1'b1, 4'd3,  32'h0000_B200, 4'd3, 32'h0000_B200}, // R7 live via user
    {1'b1, 4'd2,  32'h0000_A200, 4'd2, 32'h0000_A200}, // R7 intr shadow
    {1'b1, 4'd0,  32'h0000_00C0, 4'd0, 32'h0000_00C0}, // R6 no flip
    {1'b0, 4'd0,  32'h0000_0000, 4'd3, 32'h0000_B200}, // R6 live kept
    {1'b1, 4'd0,  32'h0000_4000, 4'd0, 32'h0000_4000}, // R5 flip down
    {1'b0, 4'd0,  32'h0000_0000, 4'd2, 32'h0000_A200}, // R5 live restored
    {1'b0, 4'd0,  32'h0000_0000, 4'd3, 32'h0000_B200}  // R5 user shadow
  };
  localparam int TREQ [0:NV-1] = '{11,11,11,8,8,9,10,10,7,7,3,4,4,7,7,6,6,5,5,5};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      #1 check("R1", rd_data, (i == 2) ? SP_INIT : 32'h0);
    end
    check("R1 sp_upd_en", {31'b0, sp_upd_en}, 32'h0);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      wr_en   = TBL[k][72];
      wr_idx  = TBL[k][71:68];
      wr_data = TBL[k][67:36];
      rd_idx  = TBL[k][35:32];
      @(negedge clk);
      wr_en = 1'b0;
      wr_idx = 4'd15;
      #1 check($sformatf("R%0d step %0d", TREQ[k], k), rd_data, TBL[k][31:0]);
    end

    // R4: strobe and data in the cycle of a 0->1 flip (mode is 0, intr live A200, user shadow B200)
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'h0000_0080;
    #1 check("R4 strobe", {31'b0, sp_upd_en}, 32'h1);
    check("R4 data", sp_upd_data, 32'h0000_B200);
    @(negedge clk);
    wr_en = 1'b0;
    rd_idx = 4'd2;
    #1 check("R4 saved", rd_data, 32'h0000_A200);

    // R5: strobe and data in the cycle of a 1->0 flip
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'h0000_0001;
    #1 check("R5 strobe", {31'b0, sp_upd_en}, 32'h1);
    check("R5 data", sp_upd_data, 32'h0000_A200);
    @(negedge clk);
    wr_en = 1'b0;
    rd_idx = 4'd0;
    #1 check("R3 cond from status", rd_data, 32'h0000_0001);

    // R6: status write keeping mode 0 raises no strobe
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'h0000_0040;
    #1 check("R6 strobe", {31'b0, sp_upd_en}, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;

    // R12: same-cycle read returns old value
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd4; wr_data = 32'h0000_DEAD; rd_idx = 4'd4;
    #1 check("R12 old", rd_data, 32'h1234_5678);
    @(negedge clk);
    wr_en = 1'b0;
    #1 check("R12 new", rd_data, 32'h0000_DEAD);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rd_idx = 4'd4;
    #1 check("R1 spare after reset", rd_data, 32'h0);
    rd_idx = 4'd0;
    #1 check("R1 status after reset", rd_data, 32'h0);
    rd_idx = 4'd3;
    #1 check("R1 user shadow after reset", rd_data, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule